// File: doc/BRIEF.md
# Dual Baud Rate Divider Timer

This block holds two independent 16-bit divider timers, named A and B. Each one produces a one-cycle enable pulse at sixteen times the wanted baud rate. A serial receiver or transmitter that takes its timing from one of these outputs treats the pulse as a 16x sampling clock and divides it by 16 again. Each timer has its own 16-bit reload value. Software writes that value as two bytes. A single shared control byte holds a run bit and a 3-bit source select for each timer.

Everything runs in one system clock domain. Every clock source a timer can count is an enable strobe that lasts one system clock cycle. There are four sources made by prescaling the system clock (/16, /32, /64 and /128), taken from one free-running 7-bit prefix counter. There is also a crystal strobe, the crystal strobe halved, a per-timer pin strobe and a per-timer general-purpose strobe. While a timer's run bit is 0, its counter is cleared and held. When the bit goes to 1, the counter loads its reload value. It then counts down once for each selected strobe. At the end of each period it pulses its output and reloads.

Top module: `baud_timer_pair`

## Requirements
- R1: Registers are written through `reg_wr`/`reg_addr`/`reg_wdata`. The addresses are: 0 control, 1 timer A upper reload byte, 2 timer A lower reload byte, 3 timer B upper reload byte, 4 timer B lower reload byte. All registers reset to 0, and both tick outputs are low after reset.
- R2: When a timer's run bit is 0, its counter is cleared and gives no ticks, whatever strobes arrive. After the run bit goes back to 1, a full period of N strobes is needed before the next tick.
- R3: Source codes 000, 001, 010 and 011 select the system clock divided by 16, 32, 64 and 128, taken from one free-running prescaler.
- R4: Source code 100 selects every crystal strobe (`xtal_en`). Code 101 selects every second crystal strobe.
- R5: Source code 110 selects the timer's own pin strobe (`pin_en[0]` for A, `pin_en[1]` for B). Code 111 selects its own general-purpose strobe (`gp_en[0]` for A, `gp_en[1]` for B).
- R6: The reload value N is {upper byte, lower byte}, 16 bits wide. The timer pulses its tick for one cycle, in the cycle after every Nth selected strobe, and never in a cycle that does not follow a selected strobe.
- R7: A reload value of 0 acts as 1, so the timer ticks on every selected strobe.
- R8: A reload byte written while the timer runs has no effect on the count in progress. It is used from the next reload or restart.
- R9: In the control byte, bit 7 is timer B's run bit and bits 6:4 are B's source. Bit 3 is timer A's run bit and bits 2:0 are A's source. The two timers count independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| xtal_en | input | 1 | Crystal clock enable strobe |
| pin_en | input | 2 | Per-timer pin strobe (bit 0 A, bit 1 B) |
| gp_en | input | 2 | Per-timer general-purpose strobe (bit 0 A, bit 1 B) |
| tick_a | output | 1 | Timer A 16x enable pulse |
| tick_b | output | 1 | Timer B 16x enable pulse |

## Verification
The bench drives externally timed strobes in counted bursts. This checks the divide ratio exactly, including a 16-bit value of 258, where 257 strobes must give no tick and the 258th must give one. The prescaled sources are measured over windows that are whole multiples of their periods, which tells each of the four tap rates apart. Strobes sent to the wrong timer's pin or general-purpose input, strobes sent while a timer is stopped, and a reload write in the middle of a count each show whether the source select, the run bit and the reload timing keep the two timers and the two periods apart.

// File: rtl/brg_pkg.sv
// Package: shared types and constants for the dual baud rate divider timer.
// Assumes the register file is byte wide and holds exactly two timers.
package brg_pkg;

    localparam int NUM_TIMERS = 2;
    localparam int BYTE_W     = 8;
    localparam int NIBBLE_W   = 4;

    // Register addresses; the reload byte addresses are derived per timer
    localparam logic [2:0] ADDR_CTRL = 3'd0;

    typedef enum logic [2:0] {
        SRC_DIV16     = 3'b000,
        SRC_DIV32     = 3'b001,
        SRC_DIV64     = 3'b010,
        SRC_DIV128    = 3'b011,
        SRC_XTAL      = 3'b100,
        SRC_XTAL_HALF = 3'b101,
        SRC_PIN       = 3'b110,
        SRC_GP        = 3'b111
    } src_sel_e;

    typedef struct packed {
        logic     run;
        src_sel_e sel;
    } tmr_ctrl_t;

endpackage

// File: rtl/brg_prescaler.sv
// Module: brg_prescaler
// Free-running prefix counter that supplies the four system-clock taps
// (/16, /32, /64, /128) and a halved copy of the crystal strobe.
// Assumes the tap strobes are one cycle wide and shared by both timers.
module brg_prescaler #(
    parameter int PRE_W     = 7,
    parameter int FIRST_TAP = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xtal_en,
    output logic [PRE_W-FIRST_TAP:0] div_stb,
    output logic                    xtal_half_stb
);

    localparam int NUM_TAPS = PRE_W - FIRST_TAP + 1;

    logic [PRE_W-1:0] pre_cnt;
    logic             xtal_phase;

    // Advance the prefix counter every system clock cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Toggle the crystal phase on each crystal strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xtal_phase <= 1'b0;
        end else if (xtal_en) begin
            xtal_phase <= ~xtal_phase;
        end
    end

    // Each tap fires when all of its low counter bits are ones
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign div_stb[k] = &pre_cnt[FIRST_TAP+k-1:0];
    end

    // Pass every second crystal strobe
    assign xtal_half_stb = xtal_en & xtal_phase;

endmodule

// File: rtl/brg_src_mux.sv
// Module: brg_src_mux
// Chooses one of the eight count enables for one timer from its 3-bit select.
// Assumes every input is a one-cycle strobe in the system clock domain.
module brg_src_mux
    import brg_pkg::*;
#(
    parameter int NUM_TAPS = 4
) (
    input  src_sel_e            sel,
    input  logic [NUM_TAPS-1:0] div_stb,
    input  logic                xtal_en,
    input  logic                xtal_half_stb,
    input  logic                pin_en,
    input  logic                gp_en,
    output logic                src_en
);

    // Decode the select code into the chosen strobe
    always_comb begin
        unique case (sel)
            SRC_DIV16:     src_en = div_stb[0];
            SRC_DIV32:     src_en = div_stb[1];
            SRC_DIV64:     src_en = div_stb[2];
            SRC_DIV128:    src_en = div_stb[3];
            SRC_XTAL:      src_en = xtal_en;
            SRC_XTAL_HALF: src_en = xtal_half_stb;
            SRC_PIN:       src_en = pin_en;
            SRC_GP:        src_en = gp_en;
            default:       src_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/brg_down_timer.sv
// Module: brg_down_timer
// Reloadable down counter. It loads on start, decrements on each source
// strobe and pulses tick for one cycle at terminal count, then reloads.
// Assumes the reload value is only sampled at start and at terminal count.
module brg_down_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    input  logic             src_en,
    output logic             tick,
    output logic             active,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] reload_eff;

    // A reload of zero behaves as one so the timer cannot stall
    always_comb begin
        reload_eff = (reload == '0) ? ONE : reload;
    end

    // Hold cleared while stopped, load on start, count and reload while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            active <= 1'b0;
            tick   <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (!run) begin
                count  <= '0;
                active <= 1'b0;
            end else if (!active) begin
                count  <= reload_eff;
                active <= 1'b1;
            end else if (src_en) begin
                if (count == ONE) begin
                    count <= reload_eff;
                    tick  <= 1'b1;
                end else begin
                    count <= count - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/baud_timer_pair.sv
// Module: baud_timer_pair
// Top of the dual baud rate divider: register file, shared prescaler and
// one source mux plus down timer per channel.
// Assumes a single clock domain and a byte-wide write-only register port.
module baud_timer_pair
    import brg_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int ADDR_W = 3,
    parameter int PRE_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              xtal_en,
    input  logic [1:0]        pin_en,
    input  logic [1:0]        gp_en,
    output logic              tick_a,
    output logic              tick_b
);

    localparam int FIRST_TAP = 4;
    localparam int NUM_TAPS  = PRE_W - FIRST_TAP + 1;
    localparam int CNT_W     = 2 * DATA_W;

    logic [DATA_W-1:0]                  ctrl_q;
    logic [NUM_TIMERS-1:0][DATA_W-1:0]  rel_hi_q;
    logic [NUM_TIMERS-1:0][DATA_W-1:0]  rel_lo_q;

    logic [NUM_TAPS-1:0]                div_stb;
    logic                               xtal_half_stb;

    logic [NUM_TIMERS-1:0]              run_vec;
    logic [NUM_TIMERS-1:0]              src_vec;
    logic [NUM_TIMERS-1:0]              tick_vec;
    logic [NUM_TIMERS-1:0]              active_vec;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]   count_vec;

    // Capture register writes; reload bytes sit at 1+2t (upper) and 2+2t (lower)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            rel_hi_q <= '0;
            rel_lo_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CTRL) begin
                ctrl_q <= reg_wdata;
            end
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (reg_addr == ADDR_W'(1 + 2 * t)) begin
                    rel_hi_q[t] <= reg_wdata;
                end
                if (reg_addr == ADDR_W'(2 + 2 * t)) begin
                    rel_lo_q[t] <= reg_wdata;
                end
            end
        end
    end

    brg_prescaler #(
        .PRE_W     (PRE_W),
        .FIRST_TAP (FIRST_TAP)
    ) u_prescaler (
        .clk           (clk),
        .rst_n         (rst_n),
        .xtal_en       (xtal_en),
        .div_stb       (div_stb),
        .xtal_half_stb (xtal_half_stb)
    );

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
        tmr_ctrl_t nib;

        assign nib        = tmr_ctrl_t'(ctrl_q[NIBBLE_W*t +: NIBBLE_W]);
        assign run_vec[t] = nib.run;

        brg_src_mux #(
            .NUM_TAPS (NUM_TAPS)
        ) u_mux (
            .sel           (nib.sel),
            .div_stb       (div_stb),
            .xtal_en       (xtal_en),
            .xtal_half_stb (xtal_half_stb),
            .pin_en        (pin_en[t]),
            .gp_en         (gp_en[t]),
            .src_en        (src_vec[t])
        );

        brg_down_timer #(
            .CNT_W (CNT_W)
        ) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (nib.run),
            .reload ({rel_hi_q[t], rel_lo_q[t]}),
            .src_en (src_vec[t]),
            .tick   (tick_vec[t]),
            .active (active_vec[t]),
            .count  (count_vec[t])
        );
    end

    assign tick_a = tick_vec[0];
    assign tick_b = tick_vec[1];

endmodule

// File: rtl/baud_timer_pair_chk.sv
// Module: baud_timer_pair_chk
// Property checker for baud_timer_pair, attached with bind below.
module baud_timer_pair_chk #(
    parameter int N     = 2,
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N-1:0]              run_vec,
    input logic [N-1:0]              src_vec,
    input logic [N-1:0]              tick_vec,
    input logic [N-1:0]              active_vec,
    input logic [N-1:0][CNT_W-1:0]   count_vec
);

    for (genvar t = 0; t < N; t++) begin : g_chk
        // R2: a stopped timer stays silent
        p_stopped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[t] && $past(!run_vec[t])) |-> !tick_vec[t]);

        // R2: an idle timer holds a cleared counter
        p_idle_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !active_vec[t] |-> (count_vec[t] == '0));

        // R6: every tick follows a selected strobe while running
        p_tick_after_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            tick_vec[t] |-> ($past(src_vec[t]) && $past(run_vec[t])));

        // R7: a running counter never reaches zero
        p_count_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            active_vec[t] |-> (count_vec[t] != '0));
    end

endmodule

bind baud_timer_pair baud_timer_pair_chk #(
    .N     (brg_pkg::NUM_TIMERS),
    .CNT_W (2 * DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_vec    (run_vec),
    .src_vec    (src_vec),
    .tick_vec   (tick_vec),
    .active_vec (active_vec),
    .count_vec  (count_vec)
);

// File: tb/baud_timer_pair_tb_top.sv
// Directed bench for baud_timer_pair; one task per scenario.
module baud_timer_pair_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       xtal_en = 1'b0;
    logic [1:0] pin_en = '0;
    logic [1:0] gp_en = '0;
    logic       tick_a;
    logic       tick_b;

    int n_run = 0;
    int n_fail = 0;
    int cnt_a = 0;
    int cnt_b = 0;
    int base_a;
    int base_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    baud_timer_pair dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .xtal_en   (xtal_en),
        .pin_en    (pin_en),
        .gp_en     (gp_en),
        .tick_a    (tick_a),
        .tick_b    (tick_b)
    );

    // Count ticks at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (tick_a) cnt_a++;
        if (tick_b) cnt_b++;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_reload(input int t, input int val);
        wr(3'(1 + 2 * t), 8'(val >> 8));
        wr(3'(2 + 2 * t), 8'(val));
    endtask

    // Restart: stop both timers, then write the new control byte
    task automatic restart(input logic [7:0] ctrl);
        wr(3'd0, 8'h00);
        wr(3'd0, ctrl);
        repeat (2) @(negedge clk);
    endtask

    task automatic mark();
        @(posedge clk); #1;
        base_a = cnt_a; base_b = cnt_b;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic pulse_gp(input logic [1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); gp_en = m;
            @(negedge clk); gp_en = '0;
        end
    endtask

    task automatic pulse_pin(input logic [1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pin_en = m;
            @(negedge clk); pin_en = '0;
        end
    endtask

    task automatic pulse_xtal(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); xtal_en = 1'b1;
            @(negedge clk); xtal_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        mark();
        repeat (300) @(negedge clk);
        pulse_gp(2'b11, 5);
        settle();
        check("R1", "tick_a after reset", cnt_a - base_a, 0);
        check("R1", "tick_b after reset", cnt_b - base_b, 0);
    endtask

    task automatic t_prescale(input logic [2:0] sel, input int rel, input int win, input int exp);
        set_reload(0, rel);
        restart({5'b0000_1, sel});
        mark();
        repeat (win) @(posedge clk);
        #1;
        check("R3", $sformatf("prescale sel %0d", sel), cnt_a - base_a, exp);
    endtask

    task automatic t_xtal();
        set_reload(0, 3);
        restart(8'h0C);
        mark();
        pulse_xtal(12);
        settle();
        check("R4", "crystal direct", cnt_a - base_a, 4);
        restart(8'h0D);
        mark();
        pulse_xtal(12);
        settle();
        check("R4", "crystal halved", cnt_a - base_a, 2);
    endtask

    task automatic t_pin_gp();
        set_reload(1, 2);
        restart(8'hE0);
        mark();
        pulse_pin(2'b01, 5);
        settle();
        check("R5", "B ignores A pin", cnt_b - base_b, 0);
        mark();
        pulse_pin(2'b10, 4);
        settle();
        check("R5", "B own pin", cnt_b - base_b, 2);
        restart(8'hF0);
        mark();
        pulse_gp(2'b01, 4);
        pulse_gp(2'b10, 4);
        settle();
        check("R5", "B own gp only", cnt_b - base_b, 2);
    endtask

    task automatic t_wide();
        set_reload(0, 258);
        restart(8'h0F);
        mark();
        pulse_gp(2'b01, 257);
        settle();
        check("R6", "257 of 258 strobes", cnt_a - base_a, 0);
        pulse_gp(2'b01, 1);
        settle();
        check("R6", "258th strobe", cnt_a - base_a, 1);
        // exact cycle: tick one cycle after the enabling strobe
        set_reload(0, 1);
        restart(8'h0F);
        @(negedge clk); gp_en = 2'b01;
        @(negedge clk); gp_en = 2'b00;
        check("R6", "tick cycle after strobe", int'(tick_a), 1);
        @(negedge clk);
        check("R6", "tick one cycle wide", int'(tick_a), 0);
    endtask

    task automatic t_zero();
        set_reload(0, 0);
        restart(8'h0F);
        mark();
        pulse_gp(2'b01, 7);
        settle();
        check("R7", "reload zero acts as one", cnt_a - base_a, 7);
    endtask

    task automatic t_midwrite();
        set_reload(0, 10);
        restart(8'h0F);
        mark();
        pulse_gp(2'b01, 3);
        set_reload(0, 2);
        pulse_gp(2'b01, 6);
        settle();
        check("R8", "no tick before old period ends", cnt_a - base_a, 0);
        pulse_gp(2'b01, 5);
        settle();
        check("R8", "new value after reload", cnt_a - base_a, 3);
    endtask

    task automatic t_runbit();
        set_reload(0, 4);
        restart(8'h0F);
        mark();
        pulse_gp(2'b01, 3);
        wr(3'd0, 8'h07);
        pulse_gp(2'b01, 4);
        settle();
        check("R2", "stopped gives no ticks", cnt_a - base_a, 0);
        wr(3'd0, 8'h0F);
        repeat (2) @(negedge clk);
        pulse_gp(2'b01, 3);
        settle();
        check("R2", "restart clears count", cnt_a - base_a, 0);
        pulse_gp(2'b01, 1);
        settle();
        check("R2", "full period after restart", cnt_a - base_a, 1);
    endtask

    task automatic t_pack();
        set_reload(0, 1);
        set_reload(1, 3);
        restart(8'hF7);
        mark();
        pulse_gp(2'b11, 6);
        settle();
        check("R9", "A stopped by bit 3", cnt_a - base_a, 0);
        check("R9", "B runs by bit 7", cnt_b - base_b, 2);
        restart(8'h7F);
        mark();
        pulse_gp(2'b11, 6);
        settle();
        check("R9", "A runs by bit 3", cnt_a - base_a, 6);
        check("R9", "B stopped by bit 7", cnt_b - base_b, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "tick_a reset level", int'(tick_a), 0);
        check("R1", "tick_b reset level", int'(tick_b), 0);
        t_reset();
        t_prescale(3'b000, 2, 512, 16);
        t_prescale(3'b001, 1, 256, 8);
        t_prescale(3'b010, 1, 256, 4);
        t_prescale(3'b011, 1, 512, 4);
        t_xtal();
        t_pin_gp();
        t_wide();
        t_zero();
        t_midwrite();
        t_runbit();
        t_pack();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule